// File: doc/BRIEF.md
# Look-ahead pipelined serial CRC-9 encoder

This block divides a serial message by the generator y^9 + y^8 + y + 1 and delivers the 9-bit remainder. It takes one bit per clock. The serial division register has a tight feedback path through the two top coefficients. Here that path is rewritten as a K-step look-ahead recurrence: the loop holds K copies of the state, so each register in the loop carries about a K-th of the XOR depth. The input side of the recurrence is retimed into K-1 register stages. Because of those stages, the remainder appears K-1 cycles later than it would from a plain bit-serial divider. The value of the remainder is exactly the same.

A caller pulses the start input to clear the encoder. It then presents the message with the most significant coefficient first, one bit per clock while the valid input is high, and marks the final bit with the last input. Cycles with valid low may appear anywhere inside the message. Done rises a fixed number of cycles after the final bit. The remainder and done then hold until the next start. The parameter PIPE_DEPTH selects K. The intended values are 1 (no look-ahead), 2 and 4.

Top module: `crc_la_serial_enc`

## Requirements
- R1: When done is high, crc_o equals M(y)·y^9 mod (y^9+y^8+y+1). M(y) takes the first accepted bit as its highest coefficient. The division starts from zero, with no bit reflection and no final inversion, so crc_o bit 8 is the y^8 coefficient.
- R2: PIPE_DEPTH = K sets the extra latency to K-1 cycles. For a 9-bit message sent on consecutive cycles, done is first seen high 9, 10 or 12 cycles after the edge that samples the first bit (that edge counted as cycle 1), for K = 1, 2 or 4.
- R3: A start pulse makes done 0 and crc_o 0 from the next edge. A bit presented in the same cycle as start is not part of the message.
- R4: A bit is taken only on an edge where valid is high, start is low and a message is open. Idle cycles between bits do not change the remainder.
- R5: If the final bit is sampled on edge e, done is high from edge e+K-1 and not before. Done is never high while a message is open.
- R6: After done rises, crc_o and done hold until the next start. Valid bits and last markers arriving in that interval are ignored.
- R7: While reset is asserted, done is 0 and crc_o is 0.
- R8: Messages shorter than K bits, including a single bit, give the correct remainder. The single bit 1 gives 9'h103.
- R9: A start during an open message discards the partial message. Only the bits after the new start are encoded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that clears the encoder and opens a message |
| bit_i | input | 1 | Message bit, highest coefficient first |
| bit_vld_i | input | 1 | bit_i carries a message bit this cycle |
| bit_last_i | input | 1 | Marks the valid bit as the final one of the message |
| crc_o | output | 9 | Remainder, bit 8 is the y^8 coefficient |
| done_o | output | 1 | Remainder on crc_o is final |

## Verification
A wrong look-ahead matrix or a mis-ordered state ring corrupts the remainder. The error shows at the ports only once done rises, K-1 cycles after the final bit. Messages are therefore compared against a plain long-division model for every depth, both with and without idle gaps. A skipped or doubled stage in the retimed input path shows up in a different way: done moves by one cycle, or it pairs the wrong state with the wrong input term. The done flag is therefore compared on every cycle against a latency counter in the bench. Start collisions, mid-message restarts and bits sent after the final bit are driven so that leaked state shows up on the cycle after start or during the hold interval.

// File: rtl/crc_la_pkg.sv
package crc_la_pkg;

    localparam int CRC_W  = 9;
    localparam int MAX_LA = 4;
    // low coefficients of y^9 + y^8 + y + 1 (y^9 implied)
    localparam logic [CRC_W-1:0] GEN_LOW = 9'h103;

    typedef logic [CRC_W-1:0] crc_t;

    typedef struct packed {
        logic vld;
        logic lst;
        crc_t term;
    } term_t;

    // Advance the serial divider n steps; bits[n-1] is consumed first.
    function automatic crc_t crc_adv(input crc_t s, input logic [MAX_LA-1:0] bits, input int n);
        crc_t r;
        logic fb;
        r = s;
        for (int i = MAX_LA - 1; i >= 0; i--) begin
            if (i < n) begin
                fb = bits[i] ^ r[CRC_W-1];
                r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? GEN_LOW : '0);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/crc_la_front.sv
module crc_la_front
    import crc_la_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr_i,
    input  logic  acc_i,
    input  logic  bit_i,
    input  logic  last_i,
    output term_t term_o
);
    typedef logic [DEPTH-1:0] win_t;

    win_t win_d, win_q;
    win_t win_nx;

    always_comb begin
        win_nx = win_t'({win_q, bit_i});
        win_d  = win_q;
        if (clr_i) begin
            win_d = '0;
        end else if (acc_i) begin
            win_d = win_nx;
        end
        term_o.vld  = acc_i;
        term_o.lst  = acc_i & last_i;
        // input half of the look-ahead: last DEPTH bits driven through a zero state
        term_o.term = crc_adv('0, MAX_LA'(win_nx), DEPTH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

endmodule

// File: rtl/crc_lat_pipe.sv
module crc_lat_pipe
    import crc_la_pkg::*;
#(
    parameter int LAT = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr_i,
    input  term_t din_i,
    output term_t dout_o
);
    term_t [LAT-1:0] st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end else begin
            st_d[0] = din_i;
            for (int j = 1; j < LAT; j++) st_d[j] = st_q[j-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout_o = st_q[LAT-1];

endmodule

// File: rtl/crc_la_core.sv
module crc_la_core
    import crc_la_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr_i,
    input  term_t term_i,
    output crc_t  crc_o,
    output logic  done_o
);
    typedef struct packed {
        crc_t [DEPTH-1:0] ring;
        logic             done;
    } core_t;

    core_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end else if (term_i.vld) begin
            // state k = A^DEPTH * state (k-DEPTH) xor input term
            st_d.ring[0] = crc_adv(st_q.ring[DEPTH-1], '0, DEPTH) ^ term_i.term;
            for (int j = 1; j < DEPTH; j++) st_d.ring[j] = st_q.ring[j-1];
            if (term_i.lst) st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign crc_o  = st_q.ring[0];
    assign done_o = st_q.done;

endmodule

// File: rtl/crc_la_serial_enc.sv
module crc_la_serial_enc
    import crc_la_pkg::*;
#(
    parameter int PIPE_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             bit_i,
    input  logic             bit_vld_i,
    input  logic             bit_last_i,
    output logic [CRC_W-1:0] crc_o,
    output logic             done_o
);
    localparam int LAT = PIPE_DEPTH - 1;
    localparam int CW  = $clog2(LAT + 2);

    typedef struct packed {
        logic run;
    } ctl_t;

    ctl_t  ctl_d, ctl_q;
    logic  accept;
    term_t front_term, core_term;

    always_comb begin
        ctl_d  = ctl_q;
        accept = ctl_q.run & bit_vld_i & ~start_i;
        if (start_i)                 ctl_d.run = 1'b1;
        else if (accept & bit_last_i) ctl_d.run = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    crc_la_front #(.DEPTH(PIPE_DEPTH)) u_front (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (start_i),
        .acc_i  (accept),
        .bit_i  (bit_i),
        .last_i (bit_last_i),
        .term_o (front_term)
    );

    generate
        if (LAT == 0) begin : g_direct
            assign core_term = front_term;
        end else begin : g_retime
            crc_lat_pipe #(.LAT(LAT)) u_pipe (
                .clk    (clk),
                .rst_n  (rst_n),
                .clr_i  (start_i),
                .din_i  (front_term),
                .dout_o (core_term)
            );
        end
    endgenerate

    crc_la_core #(.DEPTH(PIPE_DEPTH)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (start_i),
        .term_i (core_term),
        .crc_o  (crc_o),
        .done_o (done_o)
    );

    // cycles since the final bit was taken, saturating; supports the latency check
    logic [CW-1:0] since_last_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         since_last_q <= CW'(LAT + 1);
        else if (start_i)                   since_last_q <= CW'(LAT + 1);
        else if (accept & bit_last_i)       since_last_q <= '0;
        else if (since_last_q != CW'(LAT + 1)) since_last_q <= since_last_q + 1'b1;
    end

    // R3
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!done_o && crc_o == '0));

    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(crc_o)));

    // R5
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (since_last_q == CW'(LAT)));

    // R5
    done_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.run |-> !done_o);

endmodule

// File: tb/test_crc_la_serial_enc.sv
`timescale 1ns/1ps
module test_crc_la_serial_enc;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, bitv = 1'b0, vld = 1'b0, last = 1'b0;

    always #2 clk = ~clk;

    logic [8:0] crc1, crc2, crc4;
    logic       done1, done2, done4;

    crc_la_serial_enc #(.PIPE_DEPTH(1)) i_crc_la_serial_enc_p1 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .bit_i(bitv), .bit_vld_i(vld),
        .bit_last_i(last), .crc_o(crc1), .done_o(done1));
    crc_la_serial_enc #(.PIPE_DEPTH(2)) i_crc_la_serial_enc_p2 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .bit_i(bitv), .bit_vld_i(vld),
        .bit_last_i(last), .crc_o(crc2), .done_o(done2));
    crc_la_serial_enc #(.PIPE_DEPTH(4)) i_crc_la_serial_enc (
        .clk(clk), .rst_n(rst_n), .start_i(start), .bit_i(bitv), .bit_vld_i(vld),
        .bit_last_i(last), .crc_o(crc4), .done_o(done4));

    int checks = 0, fails = 0;
    string cur_tag = "R1";

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    bit   msgq[$];
    int   cyc = 0, cnt = 0, first_edge = 0, msg_len = 0;
    bit   running = 0, have_last = 0, just_start = 0, contiguous = 0;
    logic [8:0] exp_rem = '0;

    function automatic logic [8:0] ref_crc();
        logic [8:0] r = '0;
        logic top;
        for (int k = 0; k < msgq.size() + 9; k++) begin
            top = r[8];
            r = {r[7:0], (k < msgq.size()) ? msgq[k] : 1'b0};
            if (top) r = r ^ 9'h103;
        end
        return r;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            running = 0; have_last = 0; cnt = 0; just_start = 0;
        end else begin
            just_start = 0;
            if (start) begin
                running = 1; have_last = 0; msgq.delete(); just_start = 1;
            end else if (vld && running) begin
                if (msgq.size() == 0) first_edge = cyc;
                msgq.push_back(bitv);
                if (last) begin
                    running = 0; have_last = 1; cnt = 0;
                    exp_rem = ref_crc(); msg_len = msgq.size();
                end
            end else if (have_last && cnt < 1000) begin
                cnt++;
            end
        end
    end

    logic [8:0] crc_a [3];
    logic       done_a [3];
    bit         prev_done [3] = '{0, 0, 0};
    int         lat_a [3] = '{0, 1, 3};
    bit         wd_hit = 0;

    always_comb begin
        crc_a[0] = crc1; crc_a[1] = crc2; crc_a[2] = crc4;
        done_a[0] = done1; done_a[1] = done2; done_a[2] = done4;
    end

    always @(negedge clk) begin
        if (!wd_hit) begin
            for (int i = 0; i < 3; i++) begin
                if (!rst_n) begin
                    // R7
                    chk(done_a[i] == 1'b0 && crc_a[i] == '0, "R7", "reset state",
                        {done_a[i], crc_a[i]}, 0);
                end else begin
                    bit ed;
                    ed = have_last && (cnt >= lat_a[i]);
                    // R5: done timing against final-bit edge
                    chk(done_a[i] == ed, "R5", $sformatf("done depth-idx %0d", i),
                        done_a[i], ed);
                    if (ed)
                        chk(crc_a[i] == exp_rem, cur_tag, $sformatf("remainder depth-idx %0d", i),
                            crc_a[i], exp_rem);
                    if (just_start)
                        chk(done_a[i] == 1'b0 && crc_a[i] == '0, "R3", "cleared after start",
                            {done_a[i], crc_a[i]}, 0);
                    // R2: total cycles for a gap-free message
                    if (done_a[i] && !prev_done[i] && contiguous && have_last)
                        chk((cyc - first_edge + 1) == msg_len + lat_a[i], "R2",
                            $sformatf("cycles to done depth-idx %0d", i),
                            cyc - first_edge + 1, msg_len + lat_a[i]);
                end
                prev_done[i] = done_a[i];
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000 && !wd_hit) begin
            wd_hit = 1;
            checks++; fails++;
            $display("FAIL R5 watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic run_msg(input logic [63:0] m, input int n, input int gap);
        contiguous = (gap == 0);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = n - 1; i >= 0; i--) begin
            while (gap > 0 && $urandom_range(99) < gap) begin
                vld = 1'b0; last = 1'b0;
                @(negedge clk);
            end
            vld = 1'b1; bitv = m[i]; last = (i == 0);
            @(negedge clk);
        end
        vld = 1'b0; last = 1'b0;
        repeat (14) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 / R2: nine-bit example message, gap-free
        cur_tag = "R1";
        run_msg(64'b101011010, 9, 0);

        // R8: single bit and messages shorter than the look-ahead depth
        cur_tag = "R8";
        run_msg(64'b1, 1, 0);
        for (int i = 0; i < 3; i++)
            chk(crc_a[i] == 9'h103, "R8", "single bit literal", crc_a[i], 9'h103);
        run_msg(64'b11, 2, 0);
        run_msg(64'b101, 3, 0);

        // R4: idle gaps inside the message
        cur_tag = "R4";
        run_msg(64'hB5C3_19E7_0A, 40, 50);
        run_msg(64'hB5C3_19E7_0A, 40, 0);

        // R6: traffic after the final bit must not disturb the result
        cur_tag = "R6";
        run_msg(64'h3D, 7, 0);
        for (int k = 0; k < 6; k++) begin
            vld = 1'b1; bitv = k[0]; last = k[1];
            @(negedge clk);
        end
        vld = 1'b0; last = 1'b0;
        repeat (10) @(negedge clk);

        // R3: bit presented together with start is dropped
        cur_tag = "R3";
        @(negedge clk); start = 1'b1; vld = 1'b1; bitv = 1'b1;
        @(negedge clk); start = 1'b0; bitv = 1'b0; last = 1'b1;
        @(negedge clk); vld = 1'b0; last = 1'b0;
        repeat (8) @(negedge clk);

        // R9: restart in the middle of a message
        cur_tag = "R9";
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int k = 0; k < 5; k++) begin
            vld = 1'b1; bitv = 1'b1; @(negedge clk);
        end
        vld = 1'b0;
        run_msg(64'h2B7, 10, 0);

        // R1: all-zero message and random traffic
        cur_tag = "R1";
        run_msg(64'h0, 20, 0);
        for (int t = 0; t < 60; t++) begin
            logic [63:0] m;
            m = {$urandom(), $urandom()};
            run_msg(m, $urandom_range(64, 1), (t % 3 == 0) ? 0 : $urandom_range(30));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule